// File: doc/BRIEF.md
# Boot ROM Command Sequencer

This block plays a command stream held in an on-chip ROM into a device's three-wire serial command port, so that the device can set itself up without a host. Every ROM word is 18 bits wide and carries a 2-bit tag in its upper bits. The tag marks the word as a command byte, a data byte, a byte that closes a transaction, or a jump to another ROM address. The sequencer fetches words one after another, follows jumps, and shifts each byte out MSB first while chip select is held low.

A boot can start in two ways. After reset the block counts a fixed number of sample-rate ticks (`fs_tick` pulses) and then starts reading at a fixed address. A host start pulse begins reading at once at any address the host chooses, and it may cut short whatever is running. The sequence ends when it jumps to the halt address. It stops with an error if it overruns its tick budget, if a jump points at itself, or if a jump points outside the ROM. The ROM is a synchronous array that is loaded through a plain write port.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `ser_csn`=1, `ser_clk`=0, `ser_dat`=0, `busy`=1, `done`=0 and `err`=0.
- R2: After reset is released, no serial activity occurs until WAIT_TICKS (default 2048) `fs_tick` pulses have been seen. The word read next comes from address START_ADDR (default 001h).
- R3: A `host_start` pulse in any state (during the wait, during a byte, or at rest) abandons any work in progress. In the next cycle it raises `ser_csn`, sets `busy` and clears `done` and `err`. It then reads from `host_addr` with no wait: the word is decoded two cycles later.
- R4: Bits [17:16] of a word select its kind: 00 command, 01 data, 10 data-end, 11 jump. A non-jump word sends bits [7:0], and bits [15:8] are ignored.
- R5: A byte is sent MSB first as 8 pulses on `ser_clk` with `ser_csn` low. Each bit holds `ser_clk` low for HALF_CLKS cycles and then high for HALF_CLKS cycles, and `ser_dat` changes only while `ser_clk` is low. The next word is decoded two cycles after the last pulse falls.
- R6: `ser_csn` falls when the first byte of a transaction starts. It stays low across command and data bytes and rises when a data-end (tag 10) byte completes.
- R7: A jump word (tag 11) sends nothing, and reading continues at the address in bits [9:0].
- R8: A jump whose bits [15:0] equal HALT_ADDR (default 000h) ends the run: `done`=1, `busy`=0, `ser_csn`=1. A jump to 000h at address 001h therefore skips the reset boot.
- R9: A jump whose bits [15:10] are non-zero, or whose target equals its own address, ends the run with `err`=1, `busy`=0, `ser_csn`=1.
- R10: If MAX_TICKS (default 512) `fs_tick` pulses pass while a run is active, the run stops with `err`=1, `busy`=0 and `ser_csn`=1. `err` stays set until the next reset or host start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts the delayed boot |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| host_start | input | 1 | One-cycle request to boot from `host_addr` |
| host_addr | input | ADDR_W | Start address for a host-requested boot |
| rom_we | input | 1 | ROM load write enable |
| rom_waddr | input | ADDR_W | ROM load address |
| rom_wdata | input | WORD_W | ROM load word |
| ser_csn | output | 1 | Serial chip select, active low |
| ser_clk | output | 1 | Serial bit clock |
| ser_dat | output | 1 | Serial data, MSB first |
| busy | output | 1 | Wait period or run in progress |
| done | output | 1 | Run ended on the halt jump |
| err | output | 1 | Run ended on a timeout or a bad jump |

## Verification
The bench sets the first pulse against the wait count. A design that miscounts ticks, or that starts at the wrong address after reset, shifts every later cycle. A host start is issued in the middle of a byte and again during the reset wait. A design that fails to abort would leave chip select low or send stale bits, and one that still waited would start thousands of cycles late. Stop conditions are covered by a self-jump, a jump outside the ROM, a halt jump placed at the reset address, and a stream with no end that must stop close to the tick limit. Wrong priority between these would show up as the wrong flag, or as a run that never ends. A data-end tag that failed to close the transaction would show up as a missing chip-select rise between transactions.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    TAG_CMD  = 2'b00,
    TAG_DATA = 2'b01,
    TAG_END  = 2'b10,
    TAG_JUMP = 2'b11
  } word_tag_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_READ,
    ST_DECODE,
    ST_SHIFT
  } seq_state_e;

endpackage

// File: rtl/boot_rom.sv
module boot_rom #(
  parameter int ADDR_W = 10,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // one write port and one registered read port, so the array maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/boot_ser_tx.sv
module boot_ser_tx #(
  parameter int BYTE_W    = 8,
  parameter int HALF_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              abort,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              last_in,
  output logic              ser_csn,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              finish
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int DIV_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic              active;
  logic              last_q;
  logic [BYTE_W-1:0] shreg;
  logic [BIT_W-1:0]  bit_idx;
  logic [DIV_W-1:0]  div;
  logic              div_end;
  logic              last_bit;

  assign div_end  = (div == DIV_W'(HALF_CLKS - 1));
  assign last_bit = (bit_idx == BIT_W'(BYTE_W - 1));
  // high in the cycle whose edge ends the last high phase
  assign finish   = active && div_end && ser_clk && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      last_q  <= 1'b0;
      shreg   <= '0;
      bit_idx <= '0;
      div     <= '0;
      ser_csn <= 1'b1;
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
    end else if (abort) begin
      active  <= 1'b0;
      ser_csn <= 1'b1;
      ser_clk <= 1'b0;
      ser_dat <= 1'b0;
    end else if (load) begin
      active  <= 1'b1;
      last_q  <= last_in;
      shreg   <= {byte_in[BYTE_W-2:0], 1'b0};
      bit_idx <= '0;
      div     <= '0;
      ser_csn <= 1'b0;
      ser_clk <= 1'b0;
      ser_dat <= byte_in[BYTE_W-1];
    end else if (active) begin
      if (div_end) begin
        div <= '0;
        if (!ser_clk) begin
          ser_clk <= 1'b1;
        end else begin
          ser_clk <= 1'b0;
          if (last_bit) begin
            active  <= 1'b0;
            ser_dat <= 1'b0;
            if (last_q) ser_csn <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            ser_dat <= shreg[BYTE_W-1];
            shreg   <= {shreg[BYTE_W-2:0], 1'b0};
          end
        end
      end else begin
        div <= div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 18,
  parameter int BYTE_W     = 8,
  parameter int WAIT_TICKS = 2048,
  parameter int MAX_TICKS  = 512,
  parameter int START_ADDR = 1,
  parameter int HALT_ADDR  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_tick,
  input  logic              host_start,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              tx_finish,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              tx_load,
  output logic              tx_abort,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_last,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int PAY_W  = WORD_W - 2;
  localparam int WCNT_W = $clog2(WAIT_TICKS + 1);
  localparam int TCNT_W = $clog2(MAX_TICKS + 1);

  seq_state_e        state;
  logic [ADDR_W-1:0] pc;
  logic [WCNT_W-1:0] wcnt;
  logic [TCNT_W-1:0] tcnt;

  word_tag_e         tag;
  logic [PAY_W-1:0]  payload;
  logic              running;
  logic              timeout_hit;
  logic              is_jump;
  logic              jmp_halt;
  logic              jmp_range;
  logic              jmp_self;
  logic              jmp_stop;

  always_comb begin
    tag         = word_tag_e'(rd_data[WORD_W-1 -: 2]);
    payload     = rd_data[PAY_W-1:0];
    running     = (state == ST_READ) || (state == ST_DECODE) || (state == ST_SHIFT);
    timeout_hit = running && fs_tick && (tcnt == TCNT_W'(MAX_TICKS - 1));
    is_jump     = (state == ST_DECODE) && (tag == TAG_JUMP);
    jmp_halt    = (payload == PAY_W'(HALT_ADDR));
    jmp_range   = (payload[PAY_W-1:ADDR_W] != '0);
    jmp_self    = (payload[ADDR_W-1:0] == pc);
    jmp_stop    = is_jump && (jmp_halt || jmp_range || jmp_self);
    tx_load     = (state == ST_DECODE) && (tag != TAG_JUMP);
    tx_abort    = host_start || timeout_hit || jmp_stop;
    tx_byte     = rd_data[BYTE_W-1:0];
    tx_last     = (tag == TAG_END);
  end

  assign rd_addr = pc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_WAIT;
      pc    <= ADDR_W'(START_ADDR);
      wcnt  <= '0;
      tcnt  <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
      err   <= 1'b0;
    end else if (host_start) begin
      state <= ST_READ;
      pc    <= host_addr;
      tcnt  <= '0;
      busy  <= 1'b1;
      done  <= 1'b0;
      err   <= 1'b0;
    end else if (timeout_hit) begin
      state <= ST_IDLE;
      busy  <= 1'b0;
      err   <= 1'b1;
    end else begin
      if (running && fs_tick) tcnt <= tcnt + 1'b1;
      unique case (state)
        ST_WAIT: begin
          if (fs_tick) begin
            if (wcnt == WCNT_W'(WAIT_TICKS - 1)) begin
              state <= ST_READ;
              pc    <= ADDR_W'(START_ADDR);
              tcnt  <= '0;
            end else begin
              wcnt <= wcnt + 1'b1;
            end
          end
        end
        ST_READ: state <= ST_DECODE;
        ST_DECODE: begin
          if (!is_jump) begin
            state <= ST_SHIFT;
          end else if (jmp_halt) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else if (jmp_range || jmp_self) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
            err   <= 1'b1;
          end else begin
            state <= ST_READ;
            pc    <= payload[ADDR_W-1:0];
          end
        end
        ST_SHIFT: begin
          if (tx_finish) begin
            state <= ST_READ;
            pc    <= pc + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WORD_W     = 18,
  parameter int BYTE_W     = 8,
  parameter int WAIT_TICKS = 2048,
  parameter int MAX_TICKS  = 512,
  parameter int START_ADDR = 1,
  parameter int HALT_ADDR  = 0,
  parameter int HALF_CLKS  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fs_tick,
  input  logic              host_start,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              rom_we,
  input  logic [ADDR_W-1:0] rom_waddr,
  input  logic [WORD_W-1:0] rom_wdata,
  output logic              ser_csn,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data;
  logic              tx_load;
  logic              tx_abort;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_last;
  logic              tx_finish;

  boot_rom #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_rom (
    .clk  (clk),
    .we   (rom_we),
    .waddr(rom_waddr),
    .wdata(rom_wdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  boot_ctrl #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .BYTE_W    (BYTE_W),
    .WAIT_TICKS(WAIT_TICKS),
    .MAX_TICKS (MAX_TICKS),
    .START_ADDR(START_ADDR),
    .HALT_ADDR (HALT_ADDR)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fs_tick   (fs_tick),
    .host_start(host_start),
    .host_addr (host_addr),
    .rd_data   (rd_data),
    .tx_finish (tx_finish),
    .rd_addr   (rd_addr),
    .tx_load   (tx_load),
    .tx_abort  (tx_abort),
    .tx_byte   (tx_byte),
    .tx_last   (tx_last),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  boot_ser_tx #(
    .BYTE_W   (BYTE_W),
    .HALF_CLKS(HALF_CLKS)
  ) u_tx (
    .clk    (clk),
    .rst    (rst),
    .load   (tx_load),
    .abort  (tx_abort),
    .byte_in(tx_byte),
    .last_in(tx_last),
    .ser_csn(ser_csn),
    .ser_clk(ser_clk),
    .ser_dat(ser_dat),
    .finish (tx_finish)
  );
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk (
  input logic clk,
  input logic rst,
  input logic host_start,
  input logic ser_csn,
  input logic ser_clk,
  input logic busy,
  input logic done,
  input logic err
);
  logic rst_q = 1'b0;

  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_q) begin
      reset_state_chk: assert (ser_csn && !ser_clk && busy && !done && !err)
        else $error("reset state wrong");
    end
  end

  // R5
  clk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> !ser_csn);

  // R3
  host_restart_chk: assert property (@(posedge clk) disable iff (rst)
    host_start |=> (busy && !done && !err && ser_csn));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && ser_csn && !err));

  // R9
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && ser_csn));

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (err && !host_start) |=> err);
endmodule

bind boot_seq_top boot_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .host_start(host_start),
  .ser_csn   (ser_csn),
  .ser_clk   (ser_clk),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/boot_seq_top_tb.sv
`timescale 1ns/1ps
module boot_seq_top_tb;
  localparam int HALF   = 2;
  localparam int WAITN  = 2048;
  localparam int MAXT   = 512;
  localparam int FS_DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fs_tick = 1'b0;
  logic        host_start = 1'b0;
  logic [9:0]  host_addr = '0;
  logic        rom_we = 1'b0;
  logic [9:0]  rom_waddr = '0;
  logic [17:0] rom_wdata = '0;
  logic        ser_csn, ser_clk, ser_dat, busy, done, err;

  boot_seq_top #(.HALF_CLKS(HALF), .WAIT_TICKS(WAITN), .MAX_TICKS(MAXT)) u_dut (
    .clk(clk), .rst(rst), .fs_tick(fs_tick), .host_start(host_start),
    .host_addr(host_addr), .rom_we(rom_we), .rom_waddr(rom_waddr),
    .rom_wdata(rom_wdata), .ser_csn(ser_csn), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .busy(busy), .done(done), .err(err)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit chk_en = 0;

  always @(posedge clk) cyc <= cyc + 1;

  int fs_cnt = 0;
  always @(negedge clk) begin
    fs_cnt  = (fs_cnt + 1) % FS_DIV;
    fs_tick = (fs_cnt == 0);
  end

  // ---------------- behavioural reference model ----------------
  logic [17:0] rom_img [1024];
  typedef struct packed { logic csn; logic sclk; logic sdat; } pins_t;
  pins_t sched[$];
  int    m_mode = 1;   // 0 rest, 1 wait, 2 fetch, 3 shifting
  int    m_wait = 0, m_tick = 0, m_lat = 0;
  logic [9:0] m_pc = 10'd1;
  bit    m_last = 0;
  logic  e_csn = 1, e_sclk = 0, e_sdat = 0, e_busy = 1, e_done = 0, e_err = 0;

  task automatic m_stop(input bit good);
    m_mode = 0; e_busy = 0; e_done = good; e_err = !good;
    e_csn = 1; e_sclk = 0; e_sdat = 0; sched.delete();
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 1; m_wait = 0; m_tick = 0; m_pc = 10'd1; sched.delete();
      e_csn = 1; e_sclk = 0; e_sdat = 0; e_busy = 1; e_done = 0; e_err = 0;
    end else if (host_start) begin
      m_mode = 2; m_lat = 1; m_pc = host_addr; m_tick = 0; sched.delete();
      e_csn = 1; e_sclk = 0; e_sdat = 0; e_busy = 1; e_done = 0; e_err = 0;
    end else if (m_mode >= 2 && fs_tick && m_tick == MAXT - 1) begin
      m_stop(0);
    end else begin
      if (m_mode >= 2 && fs_tick) m_tick++;
      if (m_mode == 1) begin
        if (fs_tick) begin
          m_wait++;
          if (m_wait == WAITN) begin m_mode = 2; m_lat = 1; m_pc = 10'd1; m_tick = 0; end
        end
      end else if (m_mode == 2) begin
        if (m_lat > 0) m_lat = 0;
        else begin
          logic [17:0] w;
          w = rom_img[m_pc];
          if (w[17:16] == 2'b11) begin
            if (w[15:0] == 16'd0) m_stop(1);
            else if (w[15:0] > 16'd1023 || w[9:0] == m_pc) m_stop(0);
            else begin m_pc = w[9:0]; m_lat = 1; end
          end else begin
            pins_t p;
            m_last = (w[17:16] == 2'b10);
            for (int k = 0; k < 16 * HALF; k++) begin
              p.csn = 0; p.sclk = ((k % (2 * HALF)) >= HALF); p.sdat = w[7 - k / (2 * HALF)];
              sched.push_back(p);
            end
            p = sched.pop_front();
            e_csn = p.csn; e_sclk = p.sclk; e_sdat = p.sdat;
            m_mode = 3;
          end
        end
      end else if (m_mode == 3) begin
        if (sched.size() > 0) begin
          pins_t p;
          p = sched.pop_front();
          e_csn = p.csn; e_sclk = p.sclk; e_sdat = p.sdat;
        end else begin
          e_sclk = 0; e_sdat = 0; if (m_last) e_csn = 1;
          m_pc = m_pc + 10'd1; m_mode = 2; m_lat = 1;
        end
      end
    end
  end

  task automatic cmp1(input string req, input string sig, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, sig, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp1("R6", "ser_csn", ser_csn, e_csn);
      cmp1("R5", "ser_clk", ser_clk, e_sclk);
      cmp1("R4", "ser_dat", ser_dat, e_sdat);
      cmp1("R8", "busy", busy, e_busy);
      cmp1("R8", "done", done, e_done);
      cmp1("R9", "err", err, e_err);
    end
  end

  // ---------------- serial receiver ----------------
  byte unsigned rx_q[$];
  int  rx_bits = 0, rx_pulses = 0, rx_frames = 0, first_fall = -1;
  logic [7:0] rx_sh = 0;
  logic prev_sclk = 0, prev_csn = 1;
  always @(negedge clk) begin
    if (ser_csn) rx_bits = 0;
    else if (ser_clk && !prev_sclk) begin
      rx_pulses++;
      rx_sh = {rx_sh[6:0], ser_dat};
      rx_bits++;
      if (rx_bits == 8) begin rx_q.push_back(rx_sh); rx_bits = 0; end
    end
    if (ser_csn && !prev_csn) rx_frames++;
    if (!ser_csn && prev_csn && first_fall < 0) first_fall = cyc;
    prev_sclk = ser_clk; prev_csn = ser_csn;
  end

  task automatic clear_rx();
    rx_q.delete(); rx_pulses = 0; rx_frames = 0; first_fall = -1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_bytes(input string req, input byte unsigned exp[$]);
    check(rx_q.size() == exp.size(), req, rx_q.size(), exp.size());
    foreach (exp[i]) if (i < rx_q.size()) check(rx_q[i] == exp[i], req, rx_q[i], exp[i]);
  endtask

  task automatic wr(input int a, input logic [17:0] d);
    @(negedge clk);
    rom_we = 1; rom_waddr = 10'(a); rom_wdata = d; rom_img[a] = d;
    @(negedge clk);
    rom_we = 0;
  endtask

  task automatic host_go(input int a);
    @(negedge clk);
    clear_rx();
    host_addr = 10'(a); host_start = 1;
    @(negedge clk);
    host_start = 0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    check({ser_csn, ser_clk, ser_dat, busy, done, err} == 6'b100100, "R1 reset state",
          {ser_csn, ser_clk, ser_dat, busy, done, err}, 6'b100100);
    clear_rx();
    rst = 0;
  endtask

  int t0;
  byte unsigned exp_main[$] = '{8'hA5, 8'h3C, 8'h0F, 8'h81, 8'h7E, 8'hC3};
  byte unsigned exp_self[$] = '{8'h11, 8'h22};
  byte unsigned exp_none[$] = '{};

  initial begin
    for (int i = 0; i < 1024; i++) rom_img[i] = '0;
    @(posedge clk);
    @(negedge clk);
    chk_en = 1;
    // program, loaded under reset; bits [15:8] of non-jump words hold junk (R4)
    wr(10'h001, 18'h3_0010);
    wr(10'h010, {2'b00, 8'h5A, 8'hA5});
    wr(10'h011, {2'b01, 8'hFF, 8'h3C});
    wr(10'h012, {2'b01, 8'h00, 8'h0F});
    wr(10'h013, {2'b10, 8'h99, 8'h81});
    wr(10'h014, {2'b00, 8'h12, 8'h7E});
    wr(10'h015, {2'b10, 8'h34, 8'hC3});
    wr(10'h016, 18'h3_0000);
    wr(10'h020, {2'b00, 8'hEE, 8'h11});
    wr(10'h021, {2'b10, 8'hEE, 8'h22});
    wr(10'h022, 18'h3_0022);
    wr(10'h028, 18'h3_0400);
    for (int i = 0; i < 128; i++) wr(10'h030 + i, {2'b01, 8'h00, 8'(i + 1)});

    // A: reset boot
    do_reset();
    t0 = cyc;
    wait_idle(20000);
    check(first_fall - t0 >= WAITN * FS_DIV - FS_DIV, "R2 wait before first byte", first_fall - t0, WAITN * FS_DIV);
    check_bytes("R4 bytes of reset boot", exp_main);
    check(rx_frames == 2, "R6 transactions closed by data-end", rx_frames, 2);
    check(rx_pulses == 48, "R5 eight pulses per byte", rx_pulses, 48);
    check(done && !err, "R8 halt jump ends run", {done, err}, 2'b10);
    check(rx_q.size() == 6, "R7 jump words send nothing", rx_q.size(), 6);

    // B: host start at a self jump
    host_go(10'h020);
    t0 = cyc;
    wait_idle(2000);
    check_bytes("R3 host boot bytes", exp_self);
    check(err && !done, "R9 self jump flags error", {done, err}, 2'b01);
    check(cyc - t0 < 200, "R3 host boot has no wait", cyc - t0, 200);

    // B2: jump outside the ROM
    host_go(10'h028);
    wait_idle(200);
    check_bytes("R9 out-of-range jump sends nothing", exp_none);
    check(err && !busy, "R9 out-of-range jump flags error", {busy, err}, 2'b01);

    // C: endless stream hits the tick limit
    host_go(10'h030);
    t0 = cyc;
    wait_idle(5000);
    check(err && !done, "R10 timeout flags error", {done, err}, 2'b01);
    check((cyc - t0) >= (MAXT - 1) * FS_DIV && (cyc - t0) <= (MAXT + 2) * FS_DIV,
          "R10 timeout after tick budget", cyc - t0, MAXT * FS_DIV);
    check(rx_q.size() > 10 && rx_q.size() < 128, "R10 stream cut short", rx_q.size(), 56);
    repeat (20) @(negedge clk);
    check(err && ser_csn, "R10 error held", {ser_csn, err}, 2'b11);

    // D: host restart in the middle of a byte
    host_go(10'h030);
    repeat (45) @(negedge clk);
    host_go(10'h010);
    wait_idle(2000);
    check_bytes("R3 restart mid-byte", exp_main);
    check(done, "R3 restart completes", done, 1);

    // E: halt jump at the reset address skips the boot
    wr(10'h001, 18'h3_0000);
    do_reset();
    t0 = cyc;
    wait_idle(20000);
    check(cyc - t0 >= WAITN * FS_DIV - FS_DIV, "R2 skip still waits", cyc - t0, WAITN * FS_DIV);
    check_bytes("R8 skipped boot sends nothing", exp_none);
    check(done && !err, "R8 skipped boot done", {done, err}, 2'b10);

    // F: host start during the reset wait
    do_reset();
    repeat (300) @(negedge clk);
    host_go(10'h010);
    t0 = cyc;
    wait_idle(2000);
    check(cyc - t0 < 400, "R3 host start overrides wait", cyc - t0, 400);
    check_bytes("R3 bytes after wait override", exp_main);
    check(done, "R3 wait override completes", done, 1);

    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule